// File: doc/BRIEF.md
# Interrupt Vector Mask and Pending Gate

This block sits between a device's interrupt sources and a message sender. It keeps one mask bit and one pending bit per interrupt vector, plus a single mask that covers the whole function. The device raises a one-cycle trigger on any vector. The trigger always sets that vector's pending bit, and the pending bits act as the send queue. A vector may be sent only while neither its own mask nor the function mask blocks it. A masked vector therefore stays pending. It is sent automatically once it is unmasked, even if the device has meanwhile been serviced some other way, because the device has no means to withdraw a pending bit.

Sends go out one at a time on a valid/done port. The block picks the lowest-numbered vector that is pending and not blocked. It holds that vector number with valid high until a one-cycle done pulse arrives, and only then clears the vector's pending bit. A register interface writes individual mask bits and the function mask. The function mask takes effect only when the `FUNC_MASK_EN` parameter is set.

Top module: `irq_vector_gate`

## Requirements
- R1: After a synchronous active-low reset, every vector mask bit reads 1, every pending bit reads 0, the function mask reads 0 and `send_valid_o` is 0.
- R2: A cycle with `mask_wr_en_i` high sets mask bit `mask_wr_idx_i` to `mask_wr_val_i`, and the new value is visible on `mask_o` after that clock edge. A cycle with `fmask_wr_en_i` high loads `func_mask_o` in the same way.
- R3: A trigger on bit i of `trig_i` sets pending bit i at the next clock edge, whether or not vector i is masked.
- R4: A vector whose own mask bit is 1 is never presented on the send port, and its pending bit stays set.
- R5: With `FUNC_MASK_EN`=1 and the function mask at 1, no vector is presented for sending. After the function mask is cleared, a pending, unmasked vector is presented two clock edges after the clearing write.
- R6: When a pending vector becomes unblocked, a send for it starts without any new trigger.
- R7: When the port is idle, the vector chosen is the lowest-numbered vector that is pending and not blocked.
- R8: While `send_valid_o` is high and `send_done_i` is low, `send_valid_o` and `send_vec_o` stay unchanged in the next cycle. Only one send is outstanding at a time.
- R9: A pending bit is cleared only by the clock edge at which `send_done_i` is high for an outstanding send of that vector. It stays set while the send is outstanding.
- R10: A trigger for a vector in the same cycle as the done for that vector leaves its pending bit set, and the vector is sent again.
- R11: Masking a vector while its send is outstanding does not withdraw that send, and the done still clears its pending bit.
- R12: A `send_done_i` pulse while `send_valid_o` is low changes no pending bit and starts no send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | NUM_VEC | One-cycle trigger per vector |
| mask_wr_en_i | input | 1 | Write strobe for one vector mask bit |
| mask_wr_idx_i | input | IDX_W | Vector number for the mask write |
| mask_wr_val_i | input | 1 | Value written to the mask bit |
| fmask_wr_en_i | input | 1 | Write strobe for the function mask |
| fmask_wr_val_i | input | 1 | Value written to the function mask |
| mask_o | output | NUM_VEC | Current vector mask bits |
| func_mask_o | output | 1 | Current function mask |
| pend_o | output | NUM_VEC | Current pending bits |
| send_valid_o | output | 1 | A send is outstanding |
| send_vec_o | output | IDX_W | Vector number of the outstanding send |
| send_done_i | input | 1 | One-cycle completion of the outstanding send |

## Verification
The assertions check on every cycle the properties that do not depend on history. The send port holds steady until done. A newly presented vector was pending and unblocked in the cycle before, and no lower-numbered vector was eligible then. Triggers always land in the pending bits, and a pending bit falls only on a completed send. The bench scenarios cover the behaviour that depends on history. They sweep all mask patterns for full send order and replay on unmask, and they exercise the function mask, a same-cycle retrigger, masking during an outstanding send and a done pulse while idle.

// File: rtl/irqv_pkg.sv
// Shared types for the interrupt vector gate.
// Assumes: nothing beyond a synchronous clock domain.
package irqv_pkg;

    // State of the single-outstanding send port.
    typedef enum logic {
        SND_IDLE = 1'b0,
        SND_BUSY = 1'b1
    } snd_state_e;

endpackage

// File: rtl/irqv_mask_bank.sv
// Holds the per-vector mask bits and the function-wide mask.
// Assumes: one mask write per cycle; an index at or above NUM_VEC is dropped.
module irqv_mask_bank #(
    parameter int NUM_VEC = 8,
    parameter int IDX_W   = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_val,
    input  logic               fwr_en,
    input  logic               fwr_val,
    output logic [NUM_VEC-1:0] mask_q,
    output logic               fmask_q
);

    // Per-vector mask bit, reset to masked.
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[g] <= 1'b1;
            else if (wr_en && (int'(wr_idx) == g))
                mask_q[g] <= wr_val;
        end
    end

    // Function-wide mask, reset to open.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fmask_q <= 1'b0;
        else if (fwr_en)
            fmask_q <= fwr_val;
    end

endmodule

// File: rtl/irqv_pend_bank.sv
// Holds the pending bits; a trigger sets a bit, only a completed send clears it.
// Assumes: clr_en is a one-cycle completion for vector clr_idx.
module irqv_pend_bank #(
    parameter int NUM_VEC = 8,
    parameter int IDX_W   = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] trig,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NUM_VEC-1:0] pend_q
);

    // Per-vector pending bit; a trigger wins over a same-cycle clear.
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_bit
        logic clr_here;
        assign clr_here = clr_en && (int'(clr_idx) == g);

        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[g] <= 1'b0;
            else if (trig[g])
                pend_q[g] <= 1'b1;
            else if (clr_here)
                pend_q[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/irqv_prio_pick.sv
// Picks the lowest-numbered requesting vector.
// Assumes: purely combinational; idx is 0 when nothing requests.
module irqv_prio_pick #(
    parameter int NUM_VEC = 8,
    parameter int IDX_W   = $clog2(NUM_VEC)
) (
    input  logic [NUM_VEC-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    // Scan from the top so the lowest index is the last assignment.
    always_comb begin
        idx = '0;
        for (int k = NUM_VEC - 1; k >= 0; k--) begin
            if (req[k])
                idx = IDX_W'(k);
        end
    end

    // Any request at all.
    assign any = |req;

endmodule

// File: rtl/irqv_send_ctrl.sv
// Single-outstanding send port: captures a pick, holds it until done.
// Assumes: done is one cycle wide; a done while idle is ignored.
module irqv_send_ctrl #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pick_any,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic             done,
    output logic             valid,
    output logic [IDX_W-1:0] vec,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx
);
    import irqv_pkg::*;

    snd_state_e       state_q;
    logic [IDX_W-1:0] vec_q;

    // Send state and held vector number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SND_IDLE;
            vec_q   <= '0;
        end else begin
            case (state_q)
                SND_IDLE: if (pick_any) begin
                    state_q <= SND_BUSY;
                    vec_q   <= pick_idx;
                end
                SND_BUSY: if (done) begin
                    state_q <= SND_IDLE;
                end
                default: state_q <= SND_IDLE;
            endcase
        end
    end

    // Port outputs and the clear request to the pending bank.
    assign valid   = (state_q == SND_BUSY);
    assign vec     = vec_q;
    assign clr_en  = valid && done;
    assign clr_idx = vec_q;

endmodule

// File: rtl/irq_vector_gate.sv
// Per-vector mask and pending gate with a single-outstanding send port.
// Assumes: NUM_VEC >= 2; triggers and done are one-cycle pulses.
module irq_vector_gate #(
    parameter int NUM_VEC      = 8,
    parameter bit FUNC_MASK_EN = 1'b1,
    parameter int IDX_W        = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] trig_i,
    input  logic               mask_wr_en_i,
    input  logic [IDX_W-1:0]   mask_wr_idx_i,
    input  logic               mask_wr_val_i,
    input  logic               fmask_wr_en_i,
    input  logic               fmask_wr_val_i,
    output logic [NUM_VEC-1:0] mask_o,
    output logic               func_mask_o,
    output logic [NUM_VEC-1:0] pend_o,
    output logic               send_valid_o,
    output logic [IDX_W-1:0]   send_vec_o,
    input  logic               send_done_i
);

    logic [NUM_VEC-1:0] mask_q;
    logic               fmask_q;
    logic [NUM_VEC-1:0] pend_q;
    logic [NUM_VEC-1:0] blocked;
    logic [NUM_VEC-1:0] eligible;
    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;
    logic               clr_en;
    logic [IDX_W-1:0]   clr_idx;

    irqv_mask_bank #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .wr_en(mask_wr_en_i), .wr_idx(mask_wr_idx_i), .wr_val(mask_wr_val_i),
        .fwr_en(fmask_wr_en_i), .fwr_val(fmask_wr_val_i),
        .mask_q(mask_q), .fmask_q(fmask_q)
    );

    irqv_pend_bank #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .trig(trig_i), .clr_en(clr_en), .clr_idx(clr_idx),
        .pend_q(pend_q)
    );

    // Blocking term: the function mask joins only when the variant enables it.
    if (FUNC_MASK_EN) begin : g_fmask
        assign blocked = mask_q | {NUM_VEC{fmask_q}};
    end else begin : g_nofmask
        assign blocked = mask_q;
    end

    // Vectors that may be sent now.
    assign eligible = pend_q & ~blocked;

    irqv_prio_pick #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_pick (
        .req(eligible), .any(pick_any), .idx(pick_idx)
    );

    irqv_send_ctrl #(.IDX_W(IDX_W)) u_send (
        .clk(clk), .rst_n(rst_n),
        .pick_any(pick_any), .pick_idx(pick_idx), .done(send_done_i),
        .valid(send_valid_o), .vec(send_vec_o),
        .clr_en(clr_en), .clr_idx(clr_idx)
    );

    assign mask_o      = mask_q;
    assign func_mask_o = fmask_q;
    assign pend_o      = pend_q;

endmodule

// File: rtl/irq_vector_gate_chk.sv
// Checker for the interrupt vector gate, bound to every instance.
// Assumes: observes top-level ports only.
module irq_vector_gate_chk #(
    parameter int NUM_VEC      = 8,
    parameter bit FUNC_MASK_EN = 1'b1,
    parameter int IDX_W        = $clog2(NUM_VEC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_VEC-1:0] trig_i,
    input logic [NUM_VEC-1:0] mask_o,
    input logic               func_mask_o,
    input logic [NUM_VEC-1:0] pend_o,
    input logic               send_valid_o,
    input logic [IDX_W-1:0]   send_vec_o,
    input logic               send_done_i
);

    logic [NUM_VEC-1:0] open_now;
    logic [NUM_VEC-1:0] lower_m;

    // Vectors that were pending and unblocked, seen from the ports.
    always_comb begin
        open_now = pend_o & ~mask_o;
        if (FUNC_MASK_EN && func_mask_o)
            open_now = '0;
    end

    // Vectors numbered below the one on the send port.
    always_comb begin
        for (int k = 0; k < NUM_VEC; k++)
            lower_m[k] = (k < int'(send_vec_o));
    end

    // R8
    hold_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (send_valid_o && !send_done_i) |=> (send_valid_o && $stable(send_vec_o)));

    // R4
    start_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(send_valid_o) |-> ((($past(open_now) >> send_vec_o) & 1) != 0));

    // R7
    lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(send_valid_o) |-> (($past(open_now) & lower_m) == '0));

    // R3
    trig_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i != '0) |=> ((pend_o & $past(trig_i)) == $past(trig_i)));

    // R9
    clear_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_o) & ~pend_o) != '0) |-> $past(send_valid_o && send_done_i));

    // R9
    pending_while_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_valid_o |-> (((pend_o >> send_vec_o) & 1) != 0));

endmodule

bind irq_vector_gate irq_vector_gate_chk #(
    .NUM_VEC(NUM_VEC), .FUNC_MASK_EN(FUNC_MASK_EN), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .mask_o(mask_o),
    .func_mask_o(func_mask_o), .pend_o(pend_o), .send_valid_o(send_valid_o),
    .send_vec_o(send_vec_o), .send_done_i(send_done_i)
);

// File: tb/irq_vector_gate_tb_top.sv
module irq_vector_gate_tb_top;
    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  trig = '0;
    logic          mwr = 1'b0;
    logic [IW-1:0] midx = '0;
    logic          mval = 1'b0;
    logic          fwr = 1'b0;
    logic          fval = 1'b0;
    logic          done = 1'b0;
    logic [N-1:0]  mask_o;
    logic          fmask_o;
    logic [N-1:0]  pend_o;
    logic          valid_o;
    logic [IW-1:0] vec_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_vector_gate #(.NUM_VEC(N), .FUNC_MASK_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_i(trig),
        .mask_wr_en_i(mwr), .mask_wr_idx_i(midx), .mask_wr_val_i(mval),
        .fmask_wr_en_i(fwr), .fmask_wr_val_i(fval),
        .mask_o(mask_o), .func_mask_o(fmask_o), .pend_o(pend_o),
        .send_valid_o(valid_o), .send_vec_o(vec_o), .send_done_i(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_mask(input int idx, input bit v);
        midx = IW'(idx); mval = v; mwr = 1'b1;
        @(negedge clk);
        mwr = 1'b0;
    endtask

    task automatic wr_fmask(input bit v);
        fval = v; fwr = 1'b1;
        @(negedge clk);
        fwr = 1'b0;
    endtask

    task automatic pulse_trig(input logic [N-1:0] t);
        trig = t;
        @(negedge clk);
        trig = '0;
    endtask

    task automatic wait_valid();
        for (int w = 0; w < 20; w++) begin
            if (valid_o) break;
            @(negedge clk);
        end
    endtask

    // Serve the expected vectors in ascending order, then confirm the port is quiet.
    task automatic drain(input logic [N-1:0] exp_set, input string req);
        for (int i = 0; i < N; i++) begin
            if (exp_set[i]) begin
                wait_valid();
                chk(valid_o && vec_o == IW'(i), req, int'(vec_o), i);
                @(negedge clk);
                chk(valid_o && vec_o == IW'(i), "R8", int'(vec_o), i);
                chk(pend_o[i] == 1'b1, "R9", int'(pend_o[i]), 1);
                done = 1'b1;
                @(negedge clk);
                done = 1'b0;
                chk(valid_o == 1'b0, "R8", int'(valid_o), 0);
                chk(pend_o[i] == 1'b0, "R9", int'(pend_o[i]), 0);
            end
        end
        repeat (4) @(negedge clk);
        chk(valid_o == 1'b0, req, int'(valid_o), 0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(mask_o == '1, "R1", int'(mask_o), 255);
        chk(pend_o == '0, "R1", int'(pend_o), 0);
        chk(fmask_o == 1'b0, "R1", int'(fmask_o), 0);
        chk(valid_o == 1'b0, "R1", int'(valid_o), 0);

        // Sweep every mask pattern: R2 R3 R4 R6 R7
        for (int m = 0; m < (1 << N); m++) begin
            for (int b = 0; b < N; b++) wr_mask(b, m[b]);
            chk(mask_o == N'(m), "R2", int'(mask_o), m);
            pulse_trig('1);
            chk((pend_o | ~N'(m)) == '1, "R3", int'(pend_o), 255);
            drain(~N'(m), "R7");
            chk(pend_o == N'(m), "R4", int'(pend_o), m);
            for (int b = 0; b < N; b++) wr_mask(b, 1'b0);
            drain(N'(m), "R6");
            chk(pend_o == '0, "R6", int'(pend_o), 0);
        end

        // R5 function mask blocks everything, release timing
        wr_fmask(1'b1);
        chk(fmask_o == 1'b1, "R2", int'(fmask_o), 1);
        pulse_trig(8'h24);
        repeat (5) @(negedge clk);
        chk(valid_o == 1'b0, "R5", int'(valid_o), 0);
        chk(pend_o == 8'h24, "R5", int'(pend_o), 36);
        wr_fmask(1'b0);
        chk(valid_o == 1'b0, "R5", int'(valid_o), 0);
        @(negedge clk);
        chk(valid_o && vec_o == 3'd2, "R5", int'(vec_o), 2);
        drain(8'h24, "R5");

        // R10 trigger in the done cycle of the same vector
        pulse_trig(8'h08);
        wait_valid();
        chk(valid_o && vec_o == 3'd3, "R10", int'(vec_o), 3);
        trig = 8'h08; done = 1'b1;
        @(negedge clk);
        trig = '0; done = 1'b0;
        chk(pend_o[3] == 1'b1, "R10", int'(pend_o[3]), 1);
        drain(8'h08, "R10");

        // R11 masking during an outstanding send
        pulse_trig(8'h04);
        wait_valid();
        wr_mask(2, 1'b1);
        chk(valid_o && vec_o == 3'd2, "R11", int'(vec_o), 2);
        repeat (2) @(negedge clk);
        chk(valid_o && vec_o == 3'd2, "R11", int'(vec_o), 2);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        chk(pend_o == '0, "R11", int'(pend_o), 0);
        wr_mask(2, 1'b0);

        // R12 done while idle
        wr_mask(5, 1'b1);
        pulse_trig(8'h20);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        repeat (2) @(negedge clk);
        chk(pend_o == 8'h20, "R12", int'(pend_o), 32);
        chk(valid_o == 1'b0, "R12", int'(valid_o), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule